// File: doc/BRIEF.md
# DS2 to DS1 Stuffing Demultiplexer

This block sits behind a DS2 framer and turns the framed DS2 bit stream back into its four DS1 tributaries. The framer supplies one bit per enabled clock, a pulse on the first bit of every M-frame, and an out-of-frame flag. The block tracks the bit position inside the 1176-bit M-frame, separates the bit-interleaved information bits onto four lanes, and takes a 2-of-3 majority vote over the stuffing-control bits of each subframe. When the vote calls for a stuff, it removes that tributary's stuffing opportunity bit from the stream.

Each tributary lane gives a data bit and a one-cycle valid strobe. Overhead bits, removed stuff bits, idle cycles and out-of-frame periods all show up as missing strobes, so a downstream desynchronizer can smooth the gapped stream. Lanes 2 and 4 are inverted on extraction to undo the inversion that the multiplexing side applies.

Top module: `ds2_trib_demux`

## Requirements
- R1: Information bits within a block go to the lanes in the repeating order 1, 2, 3, 4. Each delivered bit raises exactly one lane's strobe, one clock after the enabled input cycle, and never more than one strobe at a time.
- R2: The first bit of each 49-bit block is overhead and produces no strobe. The remaining 48 bits are information.
- R3: A frame-sync pulse together with the bit enable marks that bit as the overhead bit of block 1 of subframe 1. An M-frame is four subframes of six blocks each.
- R4: In subframe i, the overhead bits of blocks 2, 4 and 5 are the stuffing-control bits of tributary i. If at least two of them are 1, the first lane-i information bit in block 6 of subframe i is discarded and gets no strobe.
- R5: If fewer than two of those control bits are 1, the opportunity bit is delivered as normal data.
- R6: A vote only applies within its own subframe. A frame-sync pulse in mid-frame clears any partial vote.
- R7: Lanes 2 and 4 output the inverted input bit. Lanes 1 and 3 output it unchanged.
- R8: While the out-of-frame input is high, no strobe is raised.
- R9: A cycle without the bit enable raises no strobe and does not advance the frame position.
- R10: After reset all strobes and data are 0, and no strobe is raised until the first frame-sync pulse.
- R11: A lane's data output changes only together with that lane's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ds2_bit | input | 1 | Incoming DS2 bit |
| ds2_en | input | 1 | Qualifies ds2_bit in this cycle |
| mf_sync | input | 1 | Marks the first bit of an M-frame |
| oof | input | 1 | Upstream framer is out of frame |
| trib_data | output | NUM_TRIB | Per-lane recovered data bit |
| trib_vld | output | NUM_TRIB | Per-lane one-cycle valid strobe |

## Verification
A position counter that is off by even one bit shows up within a single 49-bit block: strobes land on the wrong lane, or appear where an overhead bit should leave a gap. A wrong vote count is harder to see. It only surfaces at the single opportunity bit of each subframe, once every 294 enabled bits, as a strobe that is missing or extra on one lane. The bench therefore drives every control-bit pattern and checks each opportunity position. A polarity mix-up appears on the first bit of lanes 2 and 4 once all-zero and all-one data patterns are used.

// File: rtl/ds2_demux_pkg.sv
// Package: shared constants and overhead classification for the DS2 demux.
// Assumes the fixed overhead order per subframe: align, ctrl, fill, ctrl, ctrl, fill.
package ds2_demux_pkg;

    localparam int CTRL_VOTES = 3;   // control bits per subframe
    localparam int VOTE_MAJ   = 2;   // ones needed to declare a stuff

    typedef enum logic [1:0] {
        OH_ALIGN = 2'd0,
        OH_CTRL  = 2'd1,
        OH_FILL  = 2'd2
    } oh_kind_e;

    // Classify the overhead bit of a block by its index inside the subframe.
    function automatic oh_kind_e oh_kind(input int unsigned blk);
        case (blk)
            0:       return OH_ALIGN;
            1, 3, 4: return OH_CTRL;
            default: return OH_FILL;
        endcase
    endfunction

endpackage

// File: rtl/ds2_frame_counter.sv
// Frame position tracker: gives subframe, block and bit position of the
// current input bit. A sync pulse forces the current bit to position zero.
// Assumes fsync is already qualified by the bit enable.
module ds2_frame_counter #(
    parameter int NUM_SUB = 4,
    parameter int BLOCKS  = 6,
    parameter int BLK_LEN = 49,
    parameter int SUB_W   = 2,
    parameter int BLK_W   = 3,
    parameter int POS_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fsync,
    output logic [SUB_W-1:0] cur_sub,
    output logic [BLK_W-1:0] cur_blk,
    output logic [POS_W-1:0] cur_pos,
    output logic             cur_locked
);

    logic [SUB_W-1:0] sub_q;
    logic [BLK_W-1:0] blk_q;
    logic [POS_W-1:0] pos_q;
    logic             locked_q;
    logic             pos_end, blk_end, sub_end;

    assign cur_sub    = fsync ? '0 : sub_q;
    assign cur_blk    = fsync ? '0 : blk_q;
    assign cur_pos    = fsync ? '0 : pos_q;
    assign cur_locked = locked_q | fsync;

    // Detect wrap points of each counter field.
    always_comb begin
        pos_end = (cur_pos == POS_W'(BLK_LEN - 1));
        blk_end = (cur_blk == BLK_W'(BLOCKS - 1));
        sub_end = (cur_sub == SUB_W'(NUM_SUB - 1));
    end

    // Advance the position on every enabled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q    <= '0;
            blk_q    <= '0;
            pos_q    <= '0;
            locked_q <= 1'b0;
        end else if (en) begin
            locked_q <= cur_locked;
            pos_q    <= pos_end ? '0 : cur_pos + POS_W'(1);
            if (pos_end) begin
                blk_q <= blk_end ? '0 : cur_blk + BLK_W'(1);
                if (blk_end) begin
                    sub_q <= sub_end ? '0 : cur_sub + SUB_W'(1);
                end else begin
                    sub_q <= cur_sub;
                end
            end else begin
                blk_q <= cur_blk;
                sub_q <= cur_sub;
            end
        end
    end

endmodule

// File: rtl/ds2_stuff_vote.sv
// Stuff vote: counts the ones among the control bits of the current subframe.
// It reports a stuff once the count reaches the majority threshold.
// Assumes sub_start is high on the first bit of every subframe.
module ds2_stuff_vote #(
    parameter int VOTES = 3,
    parameter int MAJ   = 2,
    parameter int CNT_W = $clog2(VOTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sub_start,
    input  logic is_ctrl,
    input  logic bit_in,
    output logic stuff
);

    logic [CNT_W-1:0] cnt_q;

    // Clear at subframe start; count ones seen on control positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            if (sub_start) begin
                cnt_q <= '0;
            end else if (is_ctrl && bit_in && (cnt_q != CNT_W'(VOTES))) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign stuff = (cnt_q >= CNT_W'(MAJ));

endmodule

// File: rtl/ds2_lane_extract.sv
// Lane extractor: steers each information bit to its tributary lane,
// drops the stuffed opportunity bit, and inverts the even-numbered lanes.
// Assumes lanes are interleaved bit by bit from the first information bit.
module ds2_lane_extract #(
    parameter int NUM_TRIB = 4,
    parameter int BLOCKS   = 6,
    parameter int SUB_W    = 2,
    parameter int BLK_W    = 3,
    parameter int POS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                locked,
    input  logic                oof,
    input  logic                bit_in,
    input  logic [SUB_W-1:0]    cur_sub,
    input  logic [BLK_W-1:0]    cur_blk,
    input  logic [POS_W-1:0]    cur_pos,
    input  logic                stuff,
    output logic [NUM_TRIB-1:0] trib_data,
    output logic [NUM_TRIB-1:0] trib_vld
);

    logic [POS_W-1:0] info_idx;
    logic             info, opp, pass;
    int               lane;

    // Decode info position, target lane and the stuff opportunity.
    always_comb begin
        info_idx = cur_pos - POS_W'(1);
        info     = (cur_pos != '0);
        lane     = int'(info_idx) % NUM_TRIB;
        opp      = (cur_blk == BLK_W'(BLOCKS - 1)) && (int'(info_idx) == int'(cur_sub));
        pass     = en && locked && !oof && info && !(opp && stuff);
    end

    for (genvar k = 0; k < NUM_TRIB; k++) begin : g_lane
        localparam logic INV = ((k % 2) == 1);

        // Register the lane strobe and capture data only on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trib_vld[k]  <= 1'b0;
                trib_data[k] <= 1'b0;
            end else begin
                trib_vld[k] <= pass && (lane == k);
                if (pass && (lane == k)) begin
                    trib_data[k] <= bit_in ^ INV;
                end
            end
        end
    end

endmodule

// File: rtl/ds2_trib_demux.sv
// DS2 to DS1 demultiplexer top: tracks frame position, votes on the stuff
// control bits, and extracts four gapped tributary streams.
// Assumes an upstream framer provides mf_sync on the first M-frame bit.
module ds2_trib_demux
    import ds2_demux_pkg::*;
#(
    parameter int NUM_TRIB  = 4,
    parameter int BLOCKS    = 6,
    parameter int INFO_BITS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ds2_bit,
    input  logic                ds2_en,
    input  logic                mf_sync,
    input  logic                oof,
    output logic [NUM_TRIB-1:0] trib_data,
    output logic [NUM_TRIB-1:0] trib_vld
);

    localparam int BLK_LEN = INFO_BITS + 1;
    localparam int POS_W   = $clog2(BLK_LEN);
    localparam int BLK_W   = $clog2(BLOCKS);
    localparam int SUB_W   = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1;

    logic             sync_now, locked, sub_start, is_ctrl, stuff;
    logic [SUB_W-1:0] cur_sub;
    logic [BLK_W-1:0] cur_blk;
    logic [POS_W-1:0] cur_pos;

    // Qualify the sync and classify the current overhead bit.
    always_comb begin
        sync_now  = ds2_en && mf_sync;
        sub_start = (cur_pos == '0) && (cur_blk == '0);
        is_ctrl   = (cur_pos == '0) && (oh_kind(32'(cur_blk)) == OH_CTRL);
    end

    ds2_frame_counter #(
        .NUM_SUB(NUM_TRIB), .BLOCKS(BLOCKS), .BLK_LEN(BLK_LEN),
        .SUB_W(SUB_W), .BLK_W(BLK_W), .POS_W(POS_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ds2_en), .fsync(sync_now),
        .cur_sub(cur_sub), .cur_blk(cur_blk), .cur_pos(cur_pos),
        .cur_locked(locked)
    );

    ds2_stuff_vote #(
        .VOTES(CTRL_VOTES), .MAJ(VOTE_MAJ)
    ) u_vote (
        .clk(clk), .rst_n(rst_n), .en(ds2_en), .sub_start(sub_start),
        .is_ctrl(is_ctrl), .bit_in(ds2_bit), .stuff(stuff)
    );

    ds2_lane_extract #(
        .NUM_TRIB(NUM_TRIB), .BLOCKS(BLOCKS),
        .SUB_W(SUB_W), .BLK_W(BLK_W), .POS_W(POS_W)
    ) u_ext (
        .clk(clk), .rst_n(rst_n), .en(ds2_en), .locked(locked), .oof(oof),
        .bit_in(ds2_bit), .cur_sub(cur_sub), .cur_blk(cur_blk),
        .cur_pos(cur_pos), .stuff(stuff),
        .trib_data(trib_data), .trib_vld(trib_vld)
    );

endmodule

// File: rtl/ds2_trib_demux_chk.sv
// Checker: port-level properties of the DS2 demux, bound to every instance.
module ds2_trib_demux_chk #(
    parameter int NUM_TRIB = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ds2_en,
    input logic                mf_sync,
    input logic                oof,
    input logic [NUM_TRIB-1:0] trib_data,
    input logic [NUM_TRIB-1:0] trib_vld
);

    assert_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_vld));

    assert_sync_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ds2_en && mf_sync) |=> (trib_vld == '0));

    assert_oof_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oof |=> (trib_vld == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ds2_en |=> (trib_vld == '0));

    for (genvar k = 0; k < NUM_TRIB; k++) begin : g_hold
        assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !trib_vld[k] |-> $stable(trib_data[k]));
    end

endmodule

bind ds2_trib_demux ds2_trib_demux_chk #(.NUM_TRIB(NUM_TRIB)) u_chk (
    .clk(clk), .rst_n(rst_n), .ds2_en(ds2_en), .mf_sync(mf_sync),
    .oof(oof), .trib_data(trib_data), .trib_vld(trib_vld)
);

// File: tb/ds2_trib_demux_test.sv
module ds2_trib_demux_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       ds2_bit = 1'b0, ds2_en = 1'b0, mf_sync = 1'b0, oof = 1'b0;
    logic [3:0] trib_data, trib_vld;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ds2_trib_demux uut (
        .clk(clk), .rst_n(rst_n), .ds2_bit(ds2_bit), .ds2_en(ds2_en),
        .mf_sync(mf_sync), .oof(oof), .trib_data(trib_data), .trib_vld(trib_vld)
    );

    // Vector: [15:4] control bits (3 per subframe, C1 lowest), [3:2] data mode,
    // [1] insert idle gaps, [0] out-of-frame during subframe 3.
    localparam logic [15:0] VECS [8] = '{
        {12'h000,           2'd2, 1'b0, 1'b0},
        {12'hFFF,           2'd2, 1'b0, 1'b0},
        {12'b111_110_101_011, 2'd1, 1'b0, 1'b0},
        {12'b100_010_001_000, 2'd0, 1'b0, 1'b0},
        {12'b011_000_111_001, 2'd3, 1'b1, 1'b0},
        {12'hFFF,           2'd2, 1'b1, 1'b1},
        {12'hFFF,           2'd0, 1'b0, 1'b0},
        {12'b000_111_000_111, 2'd1, 1'b1, 1'b0}
    };

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    // Reference model state derived from the requirements.
    bit         m_lock = 1'b0, pend = 1'b0;
    int         m_sub = 0, m_blk = 0, m_pos = 0, m_cnt = 0;
    logic [3:0] m_data = '0, exp_vld = '0;
    string      pend_tag = "R1", ovr_tag = "";
    logic [14:0] lfsr = 15'h1;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check_pending();
        if (pend) begin
            n_cmp++;
            if (trib_vld !== exp_vld || trib_data !== m_data) begin
                n_bad++;
                $display("FAIL %s: vld=%b data=%b expected vld=%b data=%b",
                         pend_tag, trib_vld, trib_data, exp_vld, m_data);
            end
        end
    endtask

    task automatic send_bit(input logic b, input logic en, input logic sync, input logic of);
        @(negedge clk);
        check_pending();
        ds2_bit = b; ds2_en = en; mf_sync = sync; oof = of;
        exp_vld  = '0;
        pend_tag = en ? "R1" : "R9";
        if (en) begin
            if (sync) begin
                m_sub = 0; m_blk = 0; m_pos = 0; m_lock = 1'b1;
            end
            if (!m_lock) begin
                pend_tag = "R10";
            end else if (m_pos == 0) begin
                pend_tag = sync ? "R3" : "R2";
            end else begin
                int  lane = (m_pos - 1) % 4;
                bit  opp  = (m_blk == 5) && (m_pos - 1 == m_sub);
                bit  drop = opp && (m_cnt >= 2);
                if (opp) pend_tag = (ovr_tag != "") ? ovr_tag : (drop ? "R4" : "R5");
                else if (lane % 2 == 1) pend_tag = "R7";
                if (of) pend_tag = "R8";
                else if (!drop) begin
                    exp_vld[lane] = 1'b1;
                    m_data[lane]  = b ^ (lane % 2 == 1);
                end
            end
            if (m_pos == 0 && m_blk == 0) m_cnt = 0;
            else if (m_pos == 0 && (m_blk == 1 || m_blk == 3 || m_blk == 4) && b) m_cnt++;
            m_pos++;
            if (m_pos == 49) begin
                m_pos = 0; m_blk++;
                if (m_blk == 6) begin m_blk = 0; m_sub = (m_sub + 1) % 4; end
            end
        end
        pend = 1'b1;
    endtask

    task automatic send_frame(input logic [11:0] cb, input int dmode, input bit gap,
                              input bit oofsub, input int nbits);
        int cnt = 0;
        for (int s = 0; s < 4; s++)
            for (int bk = 0; bk < 6; bk++)
                for (int p = 0; p < 49; p++) begin
                    logic v;
                    if (cnt == nbits) return;
                    if (p == 0) begin
                        case (bk)
                            0:       v = 1'b1;
                            1:       v = cb[s*3];
                            3:       v = cb[s*3+1];
                            4:       v = cb[s*3+2];
                            default: v = s[0];
                        endcase
                    end else begin
                        case (dmode)
                            0: v = 1'b0;
                            1: v = 1'b1;
                            2: begin v = lfsr[0]; lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]}; end
                            default: v = p[0];
                        endcase
                    end
                    send_bit(v, 1'b1, (s == 0 && bk == 0 && p == 0), oofsub && s == 2);
                    if (gap && (p % 7 == 3)) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
                    cnt++;
                end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state at the ports.
        @(negedge clk);
        n_cmp++;
        if (trib_vld !== 4'b0 || trib_data !== 4'b0) begin
            n_bad++;
            $display("FAIL R10: vld=%b data=%b expected vld=0000 data=0000", trib_vld, trib_data);
        end
        // R10: enabled bits before any sync raise no strobe.
        for (int i = 0; i < 30; i++) send_bit(i[0], 1'b1, 1'b0, 1'b0);
        // Table walk: one full M-frame per vector.
        for (int v = 0; v < 8; v++)
            send_frame(VECS[v][15:4], int'(VECS[v][3:2]), VECS[v][1], VECS[v][0], 1176);
        // R6: partial vote in subframe 1 (C1=C2=1), then a restart sync with only C3=1.
        send_frame(12'h003, 2, 1'b0, 1'b0, 200);
        ovr_tag = "R6";
        send_frame(12'h004, 0, 1'b0, 1'b0, 1176);
        ovr_tag = "";
        // R9: idle cycles between frames.
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_pending();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule